// File: doc/BRIEF.md
# Network Interrupt Moderation Controller

This block sits between the receive and transmit engines of a network controller and the host interrupt input. Its four delay timers decide when the descriptors gathered so far are flushed to memory. The receive pair are a packet timer that restarts on every received frame and an absolute timer that starts with the first frame of a burst. The transmit pair are an idle timer that restarts on every completed frame and an absolute timer that starts with the first one. When a timer runs out, the block pulses a writeback request for its direction and posts that direction's cause.

Posted causes collect in a pending register. The single interrupt line is driven from the pending bits that the mask enables, and a throttle timer spaces out successive assertions. A post marked urgent skips the throttle. Other engines can post causes of their own directly. Software programs the mask, the four delays and the throttle interval through a small write port. It reads and clears the pending causes with a single read strobe.

Top module: `irq_moderator`

## Requirements
- R1: Receive packet timer. With a non-zero packet delay D, a `rx_pkt` strobe loads the timer to D, and any later strobe reloads it to D. When D cycles pass after the last strobe, `wb_rx_req` pulses for one cycle and pending bit 1 (receive-timer cause) is set, both visible after the D-th clock edge.
- R2: Receive absolute timer. With a non-zero packet delay and a non-zero absolute delay A, the first `rx_pkt` strobe starts the timer. Later strobes do not reload it while it runs, so it expires A cycles after the strobe that started it.
- R3: When either receive timer expires, both receive timers stop. The flush then yields exactly one `wb_rx_req` pulse, and the other timer raises no later one.
- R4: Transmit timers. The idle delay restarts on every `tx_done` strobe. The transmit absolute delay starts once per burst. Expiry of either pulses `wb_tx_req` and sets pending bit 0 (transmit-descriptor cause). Either expiry stops both transmit timers.
- R5: With a packet delay of zero, `rx_pkt` takes effect at the next edge: `wb_rx_req` and bit 1 are set, and the absolute timer is not started. In the same way, an idle delay of zero makes `tx_done` set `wb_tx_req` and bit 0 at once. An absolute delay of zero disables that absolute timer.
- R6: A pending bit is set whatever the mask holds. A mask bit of 1 enables the cause at the same position. `irq` is high only while some enabled cause is pending.
- R7: A mask write is evaluated at the edge that stores it. It raises `irq` at that edge when it enables a pending cause and the throttle is idle, and it drops `irq` at that edge when no enabled cause remains.
- R8: `cause_rdata` always shows the pending bits. A `cause_rd` strobe clears them at the next edge, which drops `irq`. A cause posted in the same cycle as the read survives the clear.
- R9: Throttle. When `irq` rises with a throttle value T, no new rise can follow for T*TICK_CYCLES cycles. A rise held back by the throttle happens at the edge that lies T*TICK_CYCLES+1 edges after the previous rise. A value of zero turns the throttle off.
- R10: When `ev_now` is high with a non-zero `ev_post`, the resulting enabled cause raises `irq` at the next edge, even while the throttle runs.
- R11: After the synchronous active-high `rst`, the pending bits, mask, delays, throttle value, `irq` and both writeback requests are all zero.
- R12: The `reg_sel` codes are 0 for the mask, 1 for the receive packet delay, 2 for the receive absolute delay, 3 for the transmit absolute delay, 4 for the transmit idle delay and 5 for the throttle. A new delay value applies from the next timer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pkt | input | 1 | Strobe: a frame was received |
| tx_done | input | 1 | Strobe: a frame was transmitted |
| ev_post | input | CAUSE_W | Direct cause posts from other engines |
| ev_now | input | 1 | The direct post bypasses the throttle |
| reg_we | input | 1 | Configuration write strobe |
| reg_sel | input | 3 | Configuration register select |
| reg_wdata | input | TW | Configuration write data |
| cause_rd | input | 1 | Read-and-clear strobe for the pending causes |
| cause_rdata | output | CAUSE_W | Pending cause bits |
| wb_rx_req | output | 1 | One-cycle receive descriptor writeback request |
| wb_tx_req | output | 1 | One-cycle transmit descriptor writeback request |
| irq | output | 1 | Interrupt line to the host |

## Verification
Every strobe is captured at a single edge, and the registered results appear right after it. A zero-delay post, a mask write, a clearing read and an urgent post therefore all show on the outputs one edge after they are driven. A timer event shows D edges after the strobe that loaded the timer. A throttled rise shows T*TICK_CYCLES+1 edges after the rise before it. The bench drives inputs on falling edges and counts falling edges from the strobe to find the cycle where a result is due. It checks one cycle before that point that the output is still quiet and then checks the due cycle itself. A falling-edge counter of `wb_rx_req` pulses confirms that a flush raises exactly one request.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int NTIMER = 4;

    typedef enum logic [1:0] {
        TM_RX_PKT  = 2'd0,
        TM_RX_ABS  = 2'd1,
        TM_TX_ABS  = 2'd2,
        TM_TX_IDLE = 2'd3
    } timer_e;

    typedef enum logic [2:0] {
        RS_MASK     = 3'd0,
        RS_RX_PKT   = 3'd1,
        RS_RX_ABS   = 3'd2,
        RS_TX_ABS   = 3'd3,
        RS_TX_IDLE  = 3'd4,
        RS_THROTTLE = 3'd5
    } reg_sel_e;

    // cause bit positions (software decodes these)
    localparam int CB_TXDW = 0;
    localparam int CB_RXT  = 1;

    // timers that reload on every event, as opposed to once per burst
    function automatic bit timer_retrig(int idx);
        return (idx == int'(TM_RX_PKT)) || (idx == int'(TM_TX_IDLE));
    endfunction

endpackage

// File: rtl/irqm_delay_timer.sv
module irqm_delay_timer #(
    parameter int TW     = 16,
    parameter bit RETRIG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cancel,
    input  logic [TW-1:0] load_val,
    output logic          fire
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt;
    logic          reload;

    // a once-per-burst timer only loads when idle
    assign reload = start && (RETRIG || cnt == '0);
    assign fire   = (cnt == ONE) && !reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cancel) begin
            cnt <= '0;
        end else if (reload) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    // expiry leaves the timer idle (R3)
    p_fire_idles_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> cnt == '0);

    // a reload takes the programmed delay (R1)
    p_reload_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !cancel && RETRIG) |=> cnt == $past(load_val));

    // a running burst timer ignores a new start (R2)
    p_no_rearm_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !cancel && !RETRIG && cnt > ONE) |=> cnt == $past(cnt) - ONE);

endmodule

// File: rtl/irqm_throttle.sv
module irqm_throttle #(
    parameter int TW          = 16,
    parameter int TICK_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          idle
);
    localparam int            PW      = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] PRE_TOP = PW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt;
    logic [PW-1:0] pre;

    assign idle = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            pre <= '0;
        end else if (load) begin
            cnt <= load_val;
            pre <= PRE_TOP;
        end else if (cnt != '0) begin
            if (pre == '0) begin
                pre <= PRE_TOP;
                cnt <= cnt - TW'(1);
            end else begin
                pre <= pre - PW'(1);
            end
        end
    end

    // a non-zero interval makes the throttle busy (R9)
    p_load_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !idle);

endmodule

// File: rtl/irqm_regs.sv
module irqm_regs
    import irqm_pkg::*;
#(
    parameter int TW      = 16,
    parameter int CAUSE_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [2:0]                   sel,
    input  logic [TW-1:0]                wdata,
    output logic [CAUSE_W-1:0]           mask_q,
    output logic [CAUSE_W-1:0]           mask_next,
    output logic [NTIMER-1:0][TW-1:0]    dly,
    output logic [TW-1:0]                thr
);
    assign mask_next = (we && sel == RS_MASK) ? wdata[CAUSE_W-1:0] : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            dly    <= '0;
            thr    <= '0;
        end else begin
            mask_q <= mask_next;
            if (we) begin
                case (sel)
                    RS_RX_PKT:   dly[TM_RX_PKT]  <= wdata;
                    RS_RX_ABS:   dly[TM_RX_ABS]  <= wdata;
                    RS_TX_ABS:   dly[TM_TX_ABS]  <= wdata;
                    RS_TX_IDLE:  dly[TM_TX_IDLE] <= wdata;
                    RS_THROTTLE: thr             <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // a mask write is stored at its edge (R7)
    p_mask_store_r7: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RS_MASK) |=> mask_q == $past(wdata[CAUSE_W-1:0]));

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import irqm_pkg::*;
#(
    parameter int TW          = 16,
    parameter int CAUSE_W     = 4,
    parameter int TICK_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_pkt,
    input  logic               tx_done,
    input  logic [CAUSE_W-1:0] ev_post,
    input  logic               ev_now,
    input  logic               reg_we,
    input  logic [2:0]         reg_sel,
    input  logic [TW-1:0]      reg_wdata,
    input  logic               cause_rd,
    output logic [CAUSE_W-1:0] cause_rdata,
    output logic               wb_rx_req,
    output logic               wb_tx_req,
    output logic               irq
);
    logic [CAUSE_W-1:0]        mask_q, mask_next;
    logic [NTIMER-1:0][TW-1:0] dly;
    logic [TW-1:0]             thr_val;

    irqm_regs #(.TW(TW), .CAUSE_W(CAUSE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .mask_q    (mask_q),
        .mask_next (mask_next),
        .dly       (dly),
        .thr       (thr_val)
    );

    // timer control
    logic [NTIMER-1:0] t_start, t_cancel, t_fire;
    logic rx_imm, tx_imm, post_rxt, post_txdw;

    assign rx_imm    = rx_pkt  && dly[TM_RX_PKT]  == '0;
    assign tx_imm    = tx_done && dly[TM_TX_IDLE] == '0;
    assign post_rxt  = rx_imm || t_fire[TM_RX_PKT] || t_fire[TM_RX_ABS];
    assign post_txdw = tx_imm || t_fire[TM_TX_IDLE] || t_fire[TM_TX_ABS];

    always_comb begin
        t_start[TM_RX_PKT]  = rx_pkt  && !rx_imm;
        t_start[TM_RX_ABS]  = rx_pkt  && !rx_imm && dly[TM_RX_ABS] != '0;
        t_start[TM_TX_IDLE] = tx_done && !tx_imm;
        t_start[TM_TX_ABS]  = tx_done && !tx_imm && dly[TM_TX_ABS] != '0;
        t_cancel[TM_RX_PKT]  = post_rxt;
        t_cancel[TM_RX_ABS]  = post_rxt;
        t_cancel[TM_TX_IDLE] = post_txdw;
        t_cancel[TM_TX_ABS]  = post_txdw;
    end

    for (genvar g = 0; g < NTIMER; g++) begin : g_tmr
        irqm_delay_timer #(.TW(TW), .RETRIG(timer_retrig(g))) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .start    (t_start[g]),
            .cancel   (t_cancel[g]),
            .load_val (dly[g]),
            .fire     (t_fire[g])
        );
    end

    // cause collection
    logic [CAUSE_W-1:0] tbits, post_bits, pend_q, pend_d;

    always_comb begin
        tbits          = '0;
        tbits[CB_RXT]  = post_rxt;
        tbits[CB_TXDW] = post_txdw;
    end

    assign post_bits = ev_post | tbits;
    assign pend_d    = (cause_rd ? '0 : pend_q) | post_bits;

    // line decision
    logic en_d, now_d, thr_idle, irq_d, thr_load;

    assign en_d  = |(pend_d & mask_next);
    assign now_d = ev_now && (ev_post != '0);

    always_comb begin
        if (!en_d)                  irq_d = 1'b0;
        else if (irq)               irq_d = 1'b1;
        else if (thr_idle || now_d) irq_d = 1'b1;
        else                        irq_d = 1'b0;
    end

    assign thr_load = irq_d && !irq;

    irqm_throttle #(.TW(TW), .TICK_CYCLES(TICK_CYCLES)) u_thr (
        .clk      (clk),
        .rst      (rst),
        .load     (thr_load),
        .load_val (thr_val),
        .idle     (thr_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            irq       <= 1'b0;
            wb_rx_req <= 1'b0;
            wb_tx_req <= 1'b0;
        end else begin
            pend_q    <= pend_d;
            irq       <= irq_d;
            wb_rx_req <= post_rxt;
            wb_tx_req <= post_txdw;
        end
    end

    assign cause_rdata = pend_q;

    // line only with an enabled pending cause (R6)
    p_irq_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cause_rdata & mask_q) != '0);

    // a rise needs an idle throttle or an urgent post (R9, R10)
    p_rise_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(thr_idle) || $past(ev_now)));

    // a receive flush always carries its cause (R1)
    p_wb_rx_cause_r1: assert property (@(posedge clk) disable iff (rst)
        wb_rx_req |-> cause_rdata[CB_RXT]);

    // a transmit flush always carries its cause (R4)
    p_wb_tx_cause_r4: assert property (@(posedge clk) disable iff (rst)
        wb_tx_req |-> cause_rdata[CB_TXDW]);

    // a read with nothing posted empties the causes (R8)
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (cause_rd && post_bits == '0) |=> (cause_rdata == '0 && !irq));

endmodule

// File: tb/irq_moderator_test.sv
module irq_moderator_test;
    import irqm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;
    localparam int CW = 4;
    localparam int TICK = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_pkt = 1'b0, tx_done = 1'b0;
    logic [CW-1:0] ev_post = '0;
    logic          ev_now = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [TW-1:0] reg_wdata = '0;
    logic          cause_rd = 1'b0;
    logic [CW-1:0] cause_rdata;
    logic          wb_rx_req, wb_tx_req, irq;

    int n_tests = 0;
    int n_fail  = 0;
    int wb_rx_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_moderator #(.TW(TW), .CAUSE_W(CW), .TICK_CYCLES(TICK)) uut (
        .clk(clk), .rst(rst), .rx_pkt(rx_pkt), .tx_done(tx_done),
        .ev_post(ev_post), .ev_now(ev_now), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cause_rd(cause_rd),
        .cause_rdata(cause_rdata), .wb_rx_req(wb_rx_req),
        .wb_tx_req(wb_tx_req), .irq(irq)
    );

    always @(negedge clk) if (!rst && wb_rx_req) wb_rx_cnt++;

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] s, logic [TW-1:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rx_pulse();
        rx_pkt = 1'b1; @(negedge clk); rx_pkt = 1'b0;
    endtask

    task automatic tx_pulse();
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic post(logic [CW-1:0] b, logic now);
        ev_post = b; ev_now = now; @(negedge clk); ev_post = '0; ev_now = 1'b0;
    endtask

    task automatic rd_clear();
        cause_rd = 1'b1; @(negedge clk); cause_rd = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(3); rst = 1'b0;
        chk(cause_rdata == '0, "R11 causes", int'(cause_rdata), 0);
        chk(!irq && !wb_rx_req && !wb_tx_req, "R11 outputs", int'(irq), 0);
    endtask

    task automatic t_zero_delay();
        rx_pulse();
        chk(wb_rx_req, "R5 rx immediate wb", int'(wb_rx_req), 1);
        chk(cause_rdata == 4'b0010, "R5 rx cause", int'(cause_rdata), 2);
        tick(1);
        chk(!wb_rx_req, "R5 wb single pulse", int'(wb_rx_req), 0);
        tx_pulse();
        chk(wb_tx_req && cause_rdata == 4'b0011, "R5 tx immediate", int'(cause_rdata), 3);
        chk(!irq, "R6 masked no line", int'(irq), 0);
    endtask

    task automatic t_mask();
        wr(RS_MASK, 16'h0001);
        chk(irq, "R7 mask enable raises", int'(irq), 1);
        wr(RS_MASK, 16'h0000);
        chk(!irq, "R7 mask disable drops", int'(irq), 0);
        wr(RS_MASK, 16'h0004);
        chk(!irq, "R6 enabled but not pending", int'(irq), 0);
    endtask

    task automatic t_read();
        chk(cause_rdata == 4'b0011, "R8 read shows pending", int'(cause_rdata), 3);
        rd_clear();
        chk(cause_rdata == '0, "R8 read clears", int'(cause_rdata), 0);
        wr(RS_MASK, 16'h000F);
        post(4'b1000, 1'b0);
        chk(irq, "R6 direct post raises", int'(irq), 1);
        ev_post = 4'b0100; cause_rd = 1'b1;
        @(negedge clk);
        ev_post = '0; cause_rd = 1'b0;
        chk(cause_rdata == 4'b0100, "R8 post wins over clear", int'(cause_rdata), 4);
        chk(irq, "R8 line kept by new post", int'(irq), 1);
        rd_clear();
        chk(!irq, "R8 read drops line", int'(irq), 0);
    endtask

    task automatic t_rx_pkt();
        wr(RS_RX_PKT, 16'd5);   // R12 select code 1
        rx_pulse(); tick(4);
        chk(!wb_rx_req && !cause_rdata[CB_RXT], "R1 not early", int'(wb_rx_req), 0);
        tick(1);
        chk(wb_rx_req && cause_rdata[CB_RXT], "R1 expiry at D", int'(wb_rx_req), 1);
        rd_clear();
        rx_pulse(); tick(2); rx_pulse(); tick(4);
        chk(!wb_rx_req, "R1 restart delays expiry", int'(wb_rx_req), 0);
        tick(1);
        chk(wb_rx_req, "R1 expiry after last packet", int'(wb_rx_req), 1);
        rd_clear();
    endtask

    task automatic t_rx_abs();
        int c0;
        wr(RS_RX_PKT, 16'd20);
        wr(RS_RX_ABS, 16'd6);   // R12 select code 2
        c0 = wb_rx_cnt;
        rx_pulse(); tick(1); rx_pulse(); tick(3);
        chk(!wb_rx_req, "R2 absolute not early", int'(wb_rx_req), 0);
        tick(1);
        chk(wb_rx_req && cause_rdata[CB_RXT], "R2 absolute not restarted", int'(wb_rx_req), 1);
        tick(30);
        chk(wb_rx_cnt - c0 == 1, "R3 single flush", wb_rx_cnt - c0, 1);
        rd_clear();
    endtask

    task automatic t_tx();
        wr(RS_TX_IDLE, 16'd3);  // R12 select code 4
        tx_pulse(); tick(2);
        chk(!wb_tx_req, "R4 idle not early", int'(wb_tx_req), 0);
        tick(1);
        chk(wb_tx_req && cause_rdata[CB_TXDW], "R4 idle expiry", int'(cause_rdata), 1);
        rd_clear();
        wr(RS_TX_ABS, 16'd4);   // R12 select code 3
        wr(RS_TX_IDLE, 16'd10);
        tx_pulse(); tick(1); tx_pulse(); tick(1);
        chk(!wb_tx_req, "R4 absolute not early", int'(wb_tx_req), 0);
        tick(1);
        chk(wb_tx_req && cause_rdata[CB_TXDW], "R4 absolute expiry", int'(wb_tx_req), 1);
        rd_clear();
        tick(12);
        chk(!wb_tx_req && cause_rdata == '0, "R4 idle stopped by flush", int'(cause_rdata), 0);
    endtask

    task automatic t_throttle();
        bit held;
        wr(RS_THROTTLE, 16'd2); // R12 select code 5
        post(4'b0100, 1'b0);
        chk(irq, "R9 first rise free", int'(irq), 1);
        rd_clear();
        chk(!irq, "R9 cleared", int'(irq), 0);
        post(4'b0100, 1'b0);
        held = !irq;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            held = held && !irq;
        end
        chk(held, "R9 held during window", int'(irq), 0);
        tick(1);
        chk(irq, "R9 rise at window end", int'(irq), 1);
        rd_clear();
        post(4'b1000, 1'b1);
        chk(irq, "R10 urgent bypasses throttle", int'(irq), 1);
        rd_clear();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_zero_delay();
        t_mask();
        t_read();
        t_rx_pkt();
        t_rx_abs();
        t_tx();
        t_throttle();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
        end
    end

endmodule